// File: doc/BRIEF.md
# Stepper Step Counter with Slow-Down Compare

This block holds the remaining-step count of one stepper motor channel. Software loads a 24-bit magnitude in two writes: the upper byte is staged first, and the write of the lower 16 bits commits both halves to the counter at once. Each counted pulse takes one off the count. The pulses come either from the channel's own step generator or from a quadrature encoder, chosen by a select input. The encoder phases are synchronised and then decoded on every edge of either phase.

When a decrement brings the count to zero, the block emits a one-cycle terminal pulse that the channel uses to drop its run request. A 16-bit slow-down value is compared against the upper 16 bits of the count. The first cycle of equality yields a one-cycle slow-down pulse that starts the ramp down. The slow-down value is the number of ramp-down steps divided by 256, less one. Both halves of the count can be read live. A disable input freezes counting and has no other effect.

Top module: `stepper_pulse_counter`

## Requirements
- R1: While reset is asserted and right after it, the count reads 0 on both read ports, and term_o, slow_o and enc_dir_o are 0.
- R2: A high-byte write alone leaves the count unchanged. A low-word write loads the count as {staged high byte, low word} at the next edge. The staged byte persists for later loads. A high-byte write in the same cycle as a low-word write applies only to later loads.
- R3: With enc_sel_i = 0 and cnt_dis_i = 0, each cycle with step_pulse_i high takes the count down by one at that edge. Encoder activity has no effect on the count in this mode.
- R4: With enc_sel_i = 1 and cnt_dis_i = 0, a change of exactly one phase takes the count down by one at the third rising edge after the change is presented. A change of both phases at once is ignored, and so is step_pulse_i.
- R5: enc_dir_o becomes 1 for each single-phase edge of the sequence {a,b} = 00, 10, 11, 01, 00 and 0 for each edge of the reverse sequence, at the same edge as the corresponding decrement would occur. It holds its value across a double transition. It tracks the encoder whatever the source select or disable.
- R6: With cnt_dis_i = 1 the count does not change except by a load, and no terminal pulse is produced.
- R7: term_o is high for exactly the one cycle after an edge at which a decrement took the count from 1 to 0. A load of 0 does not raise it.
- R8: A decrement at count 0 wraps the count to 0xFFFFFF without raising term_o.
- R9: slow_o is high for one cycle, one cycle after the count's upper 16 bits first become equal to the slow-down register, whether by counting, load or slow-down write. A held equality does not raise it again. The equality that exists at reset does not raise it.
- R10: A low-word write in the same cycle as a counted pulse loads the written value, and that pulse is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_pulse_i | input | 1 | One-cycle pulse per generated step |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| enc_sel_i | input | 1 | Count source: 1 encoder, 0 step pulses |
| cnt_dis_i | input | 1 | Freeze counting |
| hi_wr_i | input | 1 | Stage upper count byte |
| hi_wdata_i | input | 8 | Upper count byte |
| lo_wr_i | input | 1 | Write lower count word and commit load |
| lo_wdata_i | input | 16 | Lower count word |
| sd_wr_i | input | 1 | Write slow-down value |
| sd_wdata_i | input | 16 | Slow-down value |
| lo_rdata_o | output | 16 | Live lower 16 bits of the count |
| hi_rdata_o | output | 8 | Live upper 8 bits of the count |
| term_o | output | 1 | Count reached zero by decrement |
| slow_o | output | 1 | Upper count equals slow-down value |
| enc_dir_o | output | 1 | Last decoded encoder direction |

## Verification
The collision that matters is a software load landing in the same cycle as a counted pulse. A closely related case is a slow-down write landing in the cycle the count crosses the compare point. A directed step drives lo_wr_i together with step_pulse_i and expects the written value with no decrement. The random phase issues loads, staged bytes and slow-down writes near the live count while step pulses and encoder edges run. Each cycle, a bench model gives load priority over the pulse and derives term_o and slow_o from the old count and the old slow-down value.

// File: rtl/stepper_cnt_pkg.sv
package stepper_cnt_pkg;

  typedef enum logic {
    SRC_STEP = 1'b0,
    SRC_ENC  = 1'b1
  } cnt_src_e;

  typedef struct packed {
    logic a;
    logic b;
  } quad_t;

endpackage

// File: rtl/spc_quad_decoder.sv
module spc_quad_decoder #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enc_a_i,
  input  logic enc_b_i,
  output logic edge_o,
  output logic dir_o
);
  import stepper_cnt_pkg::*;

  quad_t [SYNC_STAGES-1:0] sync_q;
  quad_t                   prev_q;
  quad_t                   cur;
  quad_t                   delta;
  logic                    dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= '0;
    else         sync_q[0] <= '{a: enc_a_i, b: enc_b_i};
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= '0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign cur   = sync_q[SYNC_STAGES-1];
  assign delta = cur ^ prev_q;
  // exactly one phase moved; both moving is an illegal jump
  assign edge_o = delta.a ^ delta.b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      if (edge_o) dir_q <= prev_q.b ^ cur.a;
    end
  end

  assign dir_o = dir_q;

endmodule

// File: rtl/spc_count_core.sv
module spc_count_core #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned LO_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hi_wr_i,
  input  logic [CNT_W-LO_W-1:0]  hi_wdata_i,
  input  logic                   lo_wr_i,
  input  logic [LO_W-1:0]        lo_wdata_i,
  input  logic                   dec_i,
  output logic [CNT_W-1:0]       count_o,
  output logic                   term_o
);
  localparam int unsigned HI_W = CNT_W - LO_W;

  logic [HI_W-1:0]  hi_stage_q;
  logic [CNT_W-1:0] count_q;
  logic             term_q;
  logic             last_step;

  assign last_step = dec_i && !lo_wr_i && (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_stage_q <= '0;
    else if (hi_wr_i) hi_stage_q <= hi_wdata_i;
  end

  // load wins over a pulse in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (lo_wr_i) count_q <= {hi_stage_q, lo_wdata_i};
    else if (dec_i)   count_q <= count_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) term_q <= 1'b0;
    else         term_q <= last_step;
  end

  assign count_o = count_q;
  assign term_o  = term_q;

endmodule

// File: rtl/spc_sd_compare.sv
module spc_sd_compare #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned SD_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sd_wr_i,
  input  logic [SD_W-1:0]  sd_wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             slow_o
);
  localparam int unsigned SD_LSB = CNT_W - SD_W;

  logic [SD_W-1:0] sd_q;
  logic            match;
  logic            match_q;
  logic            slow_q;

  assign match = (count_i[CNT_W-1:SD_LSB] == sd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sd_q <= '0;
    else if (sd_wr_i) sd_q <= sd_wdata_i;
  end

  // match_q starts high so the reset-time equality is not a crossing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b1;
      slow_q  <= 1'b0;
    end else begin
      match_q <= match;
      slow_q  <= match && !match_q;
    end
  end

  assign slow_o = slow_q;

endmodule

// File: rtl/stepper_pulse_counter.sv
module stepper_pulse_counter #(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned LO_W        = 16,
  parameter int unsigned SD_W        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  step_pulse_i,
  input  logic                  enc_a_i,
  input  logic                  enc_b_i,
  input  logic                  enc_sel_i,
  input  logic                  cnt_dis_i,
  input  logic                  hi_wr_i,
  input  logic [CNT_W-LO_W-1:0] hi_wdata_i,
  input  logic                  lo_wr_i,
  input  logic [LO_W-1:0]       lo_wdata_i,
  input  logic                  sd_wr_i,
  input  logic [SD_W-1:0]       sd_wdata_i,
  output logic [LO_W-1:0]       lo_rdata_o,
  output logic [CNT_W-LO_W-1:0] hi_rdata_o,
  output logic                  term_o,
  output logic                  slow_o,
  output logic                  enc_dir_o
);
  import stepper_cnt_pkg::*;

  localparam int unsigned HI_W = CNT_W - LO_W;

  cnt_src_e         src;
  logic             enc_edge;
  logic             src_pulse;
  logic             dec;
  logic [CNT_W-1:0] count;

  spc_quad_decoder #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_quad (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enc_a_i (enc_a_i),
    .enc_b_i (enc_b_i),
    .edge_o  (enc_edge),
    .dir_o   (enc_dir_o)
  );

  assign src       = cnt_src_e'(enc_sel_i);
  assign src_pulse = (src == SRC_ENC) ? enc_edge : step_pulse_i;
  assign dec       = src_pulse && !cnt_dis_i;

  spc_count_core #(
    .CNT_W(CNT_W),
    .LO_W (LO_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_wr_i    (hi_wr_i),
    .hi_wdata_i (hi_wdata_i),
    .lo_wr_i    (lo_wr_i),
    .lo_wdata_i (lo_wdata_i),
    .dec_i      (dec),
    .count_o    (count),
    .term_o     (term_o)
  );

  spc_sd_compare #(
    .CNT_W(CNT_W),
    .SD_W (SD_W)
  ) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sd_wr_i    (sd_wr_i),
    .sd_wdata_i (sd_wdata_i),
    .count_i    (count),
    .slow_o     (slow_o)
  );

  assign lo_rdata_o = count[LO_W-1:0];
  assign hi_rdata_o = count[CNT_W-1:CNT_W-HI_W];

endmodule

// File: rtl/stepper_pulse_counter_chk.sv
module stepper_pulse_counter_chk #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned LO_W  = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  step_pulse_i,
  input logic                  enc_sel_i,
  input logic                  cnt_dis_i,
  input logic                  lo_wr_i,
  input logic [LO_W-1:0]       lo_wdata_i,
  input logic [LO_W-1:0]       lo_rdata_o,
  input logic [CNT_W-LO_W-1:0] hi_rdata_o,
  input logic                  term_o,
  input logic                  slow_o
);
  logic [CNT_W-1:0] count;
  assign count = {hi_rdata_o, lo_rdata_o};

  // R2
  lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> (lo_rdata_o == $past(lo_wdata_i)));

  // R3
  step_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enc_sel_i && step_pulse_i && !cnt_dis_i && !lo_wr_i) |=> (count == $past(count) - CNT_W'(1)));

  // R6
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_dis_i && !lo_wr_i) |=> (count == $past(count)));

  // R7
  term_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> (count == '0));

  // R7
  term_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> !term_o);

  // R9
  slow_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_o |=> !slow_o);

endmodule

bind stepper_pulse_counter stepper_pulse_counter_chk #(
  .CNT_W(CNT_W),
  .LO_W (LO_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .step_pulse_i (step_pulse_i),
  .enc_sel_i    (enc_sel_i),
  .cnt_dis_i    (cnt_dis_i),
  .lo_wr_i      (lo_wr_i),
  .lo_wdata_i   (lo_wdata_i),
  .lo_rdata_o   (lo_rdata_o),
  .hi_rdata_o   (hi_rdata_o),
  .term_o       (term_o),
  .slow_o       (slow_o)
);

// File: tb/sim_stepper_pulse_counter.sv
module sim_stepper_pulse_counter;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_pulse = 1'b0, enc_a = 1'b0, enc_b = 1'b0;
  logic        enc_sel = 1'b0, cnt_dis = 1'b0;
  logic        hi_wr = 1'b0, lo_wr = 1'b0, sd_wr = 1'b0;
  logic [7:0]  hi_data = '0;
  logic [15:0] lo_data = '0, sd_data = '0;
  logic [15:0] lo_rd;
  logic [7:0]  hi_rd;
  logic        term, slow, dir;

  int n_vec = 0;
  int n_bad = 0;

  // bench model state
  logic [23:0] m_cnt = '0;
  logic [7:0]  m_stage = '0;
  logic [15:0] m_sd = '0;
  logic        m_mq = 1'b1, m_slow = 1'b0, m_term = 1'b0, m_dir = 1'b0;
  logic [1:0]  h1 = '0, h2 = '0, h3 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepper_pulse_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_pulse_i(step_pulse),
    .enc_a_i(enc_a), .enc_b_i(enc_b), .enc_sel_i(enc_sel), .cnt_dis_i(cnt_dis),
    .hi_wr_i(hi_wr), .hi_wdata_i(hi_data), .lo_wr_i(lo_wr), .lo_wdata_i(lo_data),
    .sd_wr_i(sd_wr), .sd_wdata_i(sd_data), .lo_rdata_o(lo_rd), .hi_rdata_o(hi_rd),
    .term_o(term), .slow_o(slow), .enc_dir_o(dir)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "count", {8'h0, hi_rd, lo_rd}, {8'h0, m_cnt});
    chk("R7", "term", {31'h0, term}, {31'h0, m_term});
    chk("R9", "slow", {31'h0, slow}, {31'h0, m_slow});
    chk("R5", "dir", {31'h0, dir}, {31'h0, m_dir});
  endtask

  // expected effect of the coming rising edge, from the requirements
  task automatic model_edge();
    logic enc_edge, dec, match;
    enc_edge = ^(h2 ^ h3);                    // R4: third edge after a single-phase change
    if (enc_edge) m_dir = h3[0] ^ h2[1];      // R5
    dec = !cnt_dis && (enc_sel ? enc_edge : step_pulse);
    match = (m_cnt[23:8] == m_sd);
    m_slow = match && !m_mq;
    m_mq = match;
    m_term = !lo_wr && dec && (m_cnt == 24'd1);
    if (lo_wr)    m_cnt = {m_stage, lo_data};  // R10: load wins
    else if (dec) m_cnt = m_cnt - 24'd1;       // R8: wraps at zero
    if (hi_wr) m_stage = hi_data;
    if (sd_wr) m_sd = sd_data;
    h3 = h2; h2 = h1; h1 = {enc_a, enc_b};
  endtask

  task automatic tick(input string req);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic idle();
    step_pulse = 0; hi_wr = 0; lo_wr = 0; sd_wr = 0;
  endtask

  task automatic load(input logic [7:0] hi, input logic [15:0] lo);
    hi_wr = 1; hi_data = hi; tick("R2");
    hi_wr = 0; lo_wr = 1; lo_data = lo; tick("R2");
    lo_wr = 0;
  endtask

  task automatic enc_move(input logic a, input logic b, input string req);
    enc_a = a; enc_b = b;
    for (int i = 0; i < 4; i++) tick(req);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    tick("R1");

    // R2: staged byte alone, commit on low word, staging persists
    hi_wr = 1; hi_data = 8'h12; tick("R2");
    hi_wr = 0; tick("R2");
    lo_wr = 1; lo_data = 16'h0005; tick("R2");
    lo_data = 16'h0003; tick("R2");
    lo_wr = 0;
    hi_wr = 1; hi_data = 8'h00; lo_wr = 1; lo_data = 16'h0007; tick("R2");
    idle();
    load(8'h00, 16'h0003);

    // R3, R7: count 3 down to zero
    step_pulse = 1;
    for (int i = 0; i < 3; i++) tick("R3");
    // R8: wrap
    tick("R8");
    step_pulse = 0; tick("R8");

    // R6: disable freezes
    cnt_dis = 1; step_pulse = 1;
    for (int i = 0; i < 3; i++) tick("R6");
    // R6: no terminal pulse at count 1 while disabled
    step_pulse = 0; load(8'h00, 16'h0001);
    step_pulse = 1; tick("R6"); tick("R6");
    cnt_dis = 0; step_pulse = 0;

    // R10: load collides with a pulse
    step_pulse = 1; lo_wr = 1; lo_data = 16'h0040; tick("R10");
    idle(); tick("R10");

    // R9: slow-down crossing, held equality, leave and re-enter
    sd_wr = 1; sd_data = 16'h0001; tick("R9");
    sd_wr = 0; tick("R9");
    load(8'h00, 16'h0102);
    for (int i = 0; i < 3; i++) tick("R9");
    step_pulse = 1;
    for (int i = 0; i < 4; i++) tick("R9");
    step_pulse = 0; load(8'h00, 16'h0180); tick("R9");
    // R7: load of zero gives no terminal pulse
    load(8'h00, 16'h0000); tick("R7");

    // R4, R5: encoder source, forward then reverse, double jump, step ignored
    load(8'h00, 16'h0064);
    enc_sel = 1;
    enc_move(1, 0, "R4"); enc_move(1, 1, "R4"); enc_move(0, 1, "R4"); enc_move(0, 0, "R4");
    enc_move(0, 1, "R5"); enc_move(1, 1, "R5"); enc_move(1, 0, "R5");
    enc_move(0, 1, "R4");
    step_pulse = 1; tick("R4"); tick("R4"); step_pulse = 0;
    enc_move(0, 0, "R4");
    // R3: encoder activity ignored with step source
    enc_sel = 0;
    enc_move(1, 0, "R3"); enc_move(1, 1, "R3");

    // random phase
    for (int i = 0; i < N_RAND; i++) begin
      r = $urandom;
      step_pulse = r[0] & r[1];
      if (r[4:2] == 3'd0) enc_a = ~enc_a;
      else if (r[4:2] == 3'd1) enc_b = ~enc_b;
      else if (r[4:2] == 3'd2) begin enc_a = ~enc_a; enc_b = ~enc_b; end
      if (r[9:5] == 5'd0) enc_sel = ~enc_sel;
      cnt_dis = (r[14:10] < 5'd3);
      hi_wr = (r[19:15] == 5'd0);
      hi_data = r[26] ? 8'h00 : 8'($urandom);
      lo_wr = (r[24:20] == 5'd0);
      lo_data = r[27] ? 16'($urandom % 8) : 16'($urandom);
      sd_wr = (r[31:28] == 4'd0);
      sd_data = m_cnt[23:8] - 16'($urandom % 3);
      tick(enc_sel ? "R4" : "R3");
    end
    idle(); tick("R3");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule